// File: doc/BRIEF.md
# Boot Flash Remap and Write Guard

This block sits on the path from a processor local bus to the boot flash. The top 8 MByte of the 32-bit address space, 0xFF80_0000 to 0xFFFF_FFFF, is the boot window. The window holds four 2 MByte regions: the main image, an alternate image, an extended image and a recovery image that cannot be corrupted. Two selection straps give a 2-bit code. The code changes the order of the regions, so it decides which image the processor fetches from the boot vector after reset. A write-enable strap decides whether writes into the boot window reach the flash. A visibility strap decides which of two fixed ASCII words a small password register returns.

Every strap is active-low: a fitted link pulls the pin to ground. Each strap goes through a two-flop synchroniser and is latched once, just after reset is released. Later changes on the pins have no effect until the next reset. A state machine controls each access. After reset it stays in SYNC while the synchronisers fill. It then moves to IDLE. When it accepts a request in IDLE, it goes to XFER for an access that drives the flash, or to BLOCK for a write it refuses. From XFER or BLOCK it returns to IDLE in the next cycle, and in that cycle it acknowledges the bus. A refused write still completes on the bus and sets a sticky violation flag. Software clears the flag by writing 1 to it.

Top module: `boot_flash_guard`

## Requirements
- R1: An address is in the boot window when bits [31:23] are all ones. Addresses outside the window reach `mem_addr` unchanged, and writes to them are never blocked.
- R2: For an address in the window, `mem_addr` equals the bus address with bits [22:21] XOR-ed with the select code. The select code is {strap 3 fitted, strap 2 fitted}. All other address bits are unchanged.
- R3: When strap 1 (write enable) is not fitted, a write in the window gets an acknowledge but asserts neither `mem_cs` nor `mem_we`.
- R4: When strap 1 is fitted, a write in the window asserts `mem_cs` and `mem_we` together with the remapped address and the write data.
- R5: A read in the window is never blocked. It asserts `mem_cs` with `mem_we` low and uses the remapped address.
- R6: A blocked write sets bit 4 of the control register (word 2). The bit stays set until a register write to word 2 with bit 4 set. A write with bit 4 clear leaves it set.
- R7: Password word 0 reads 0x44617461 and word 1 reads 0x53616665 when strap 0 is fitted. Both words read 0x6C6F636B when strap 0 is not fitted. The first character is in the top byte. Register read data appears in the cycle after `reg_rd`.
- R8: Bits [3:0] of the control register read 1 for each strap 3..0 that is fitted (a low pin). Bits [31:5] read 0.
- R9: Strap pins are synchronised and latched once after reset is released. Changing the pins after that alters neither the control register, the remap nor the write gating.
- R10: After reset the machine stays in SYNC for three cycles and ignores bus requests. In IDLE, a request moves it to XFER, or to BLOCK for a refused write. `bus_ack` is high for exactly the one cycle that follows the accepted request, and the machine then returns to IDLE. During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_n | input | 4 | Strap pins, active-low: [0] visibility, [1] write enable, [3:2] select code |
| bus_req | input | 1 | Single-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access complete, one cycle |
| mem_cs | output | 1 | Flash chip select |
| mem_we | output | 1 | Flash write strobe |
| mem_addr | output | 32 | Address after remapping |
| mem_wdata | output | 32 | Write data to flash |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 2 | Register word: 0/1 password, 2 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |

## Verification
The remap is driven with three strap settings: no strap fitted (code 0, writes locked, passwords hidden), all straps fitted (code 3, writes open, passwords visible), and a mixed setting (code 1, writes open, passwords hidden). Code 0 shows that identity mapping passes addresses through. Codes 1 and 3 show which address bit each select strap flips. Addresses on both sides of the 0xFF80_0000 edge check that the window decode starts at the right place. Reads and writes are interleaved with violation clears that use bit 4 set and bit 4 clear. Strap pins are also changed after the latch, which separates latched behaviour from live pin behaviour.

// File: rtl/bfg_pkg.sv
package bfg_pkg;

    localparam int SEL_W    = 2;
    localparam int STRAP_W  = SEL_W + 2;
    localparam int VIOL_BIT = STRAP_W;

    // ASCII words returned by the password register
    localparam logic [31:0] PW_WORD_HI = 32'h4461_7461;
    localparam logic [31:0] PW_WORD_LO = 32'h5361_6665;
    localparam logic [31:0] PW_MASKED  = 32'h6C6F_636B;

    typedef enum logic [1:0] {
        ST_SYNC,
        ST_IDLE,
        ST_XFER,
        ST_BLOCK
    } bfg_state_e;

    // Bit order matches the strap pin order
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             wen;
        logic             vis;
    } strap_cfg_t;

endpackage

// File: rtl/bfg_strap_sync.sv
module bfg_strap_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_n,
    input  logic         capture,
    output logic [N-1:0] fitted
);

    logic [N-1:0] latched_n;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain        <= '1;
                latched_n[i] <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], pin_n[i]};
                if (capture) begin
                    latched_n[i] <= chain[STAGES-1];
                end
            end
        end
    end

    assign fitted = ~latched_n;

endmodule

// File: rtl/bfg_remap.sv
module bfg_remap #(
    parameter int ADDR_W    = 32,
    parameter int REGION_AW = 21,
    parameter int SEL_W     = 2
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [SEL_W-1:0]  code,
    output logic [ADDR_W-1:0] addr_out,
    output logic              in_win
);

    localparam int TAG_LSB = REGION_AW + SEL_W;

    assign in_win = &addr_in[ADDR_W-1:TAG_LSB];

    always_comb begin
        addr_out = addr_in;
        if (in_win) begin
            addr_out[TAG_LSB-1:REGION_AW] = addr_in[TAG_LSB-1:REGION_AW] ^ code;
        end
    end

endmodule

// File: rtl/bfg_regs.sv
module bfg_regs
    import bfg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic [1:0]        word,
    input  logic [DATA_W-1:0] wdata,
    input  strap_cfg_t        cfg,
    input  logic              blk_set,
    output logic [DATA_W-1:0] rdata,
    output logic              viol
);

    logic              clr;
    logic [DATA_W-1:0] ctrl;
    logic              unused_wdata;

    assign clr          = wr && (word == 2'd2) && wdata[VIOL_BIT];
    assign unused_wdata = ^wdata;

    always_comb begin
        ctrl                = '0;
        ctrl[STRAP_W-1:0]   = cfg;
        ctrl[VIOL_BIT]      = viol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol <= 1'b0;
        end else if (blk_set) begin
            viol <= 1'b1;
        end else if (clr) begin
            viol <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            unique case (word)
                2'd0:    rdata <= DATA_W'(cfg.vis ? PW_WORD_HI : PW_MASKED);
                2'd1:    rdata <= DATA_W'(cfg.vis ? PW_WORD_LO : PW_MASKED);
                2'd2:    rdata <= ctrl;
                default: rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/boot_flash_guard.sv
module boot_flash_guard
    import bfg_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int REGION_AW   = 21,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic               bus_ack,
    output logic               mem_cs,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               reg_rd,
    input  logic               reg_wr,
    input  logic [1:0]         reg_word,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata
);

    localparam int CNT_W = $clog2(SYNC_STAGES + 1);

    bfg_state_e         state, nxt;
    logic [CNT_W-1:0]   cnt;
    logic               sync_done;
    logic [STRAP_W-1:0] fitted;
    strap_cfg_t         cfg;
    logic [ADDR_W-1:0]  remapped;
    logic               in_win;
    logic [ADDR_W-1:0]  cap_addr;
    logic [DATA_W-1:0]  cap_wdata;
    logic               cap_we;
    logic               blk_set;
    logic               viol;
    logic               in_sync;
    logic               accept;

    assign sync_done = (state == ST_SYNC) && (cnt == CNT_W'(SYNC_STAGES));
    assign cfg       = strap_cfg_t'(fitted);
    assign in_sync   = (state == ST_SYNC);
    assign accept    = (state == ST_IDLE) && bus_req;

    bfg_strap_sync #(
        .N      (STRAP_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (strap_n),
        .capture (sync_done),
        .fitted  (fitted)
    );

    bfg_remap #(
        .ADDR_W    (ADDR_W),
        .REGION_AW (REGION_AW),
        .SEL_W     (SEL_W)
    ) u_remap (
        .addr_in  (bus_addr),
        .code     (cfg.sel),
        .addr_out (remapped),
        .in_win   (in_win)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SYNC;
        end else begin
            state <= nxt;
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_SYNC:  if (sync_done) nxt = ST_IDLE;
            ST_IDLE:  if (bus_req) nxt = (bus_we && in_win && !cfg.wen) ? ST_BLOCK : ST_XFER;
            ST_XFER:  nxt = ST_IDLE;
            ST_BLOCK: nxt = ST_IDLE;
            default:  nxt = ST_SYNC;
        endcase
    end

    // Sync counter and access capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            cap_addr  <= '0;
            cap_wdata <= '0;
            cap_we    <= 1'b0;
        end else begin
            if (in_sync && !sync_done) begin
                cnt <= cnt + 1'b1;
            end
            if (accept) begin
                cap_addr  <= remapped;
                cap_wdata <= bus_wdata;
                cap_we    <= bus_we;
            end
        end
    end

    // Outputs
    always_comb begin
        bus_ack   = (state == ST_XFER) || (state == ST_BLOCK);
        mem_cs    = (state == ST_XFER);
        mem_we    = (state == ST_XFER) && cap_we;
        mem_addr  = cap_addr;
        mem_wdata = cap_wdata;
        blk_set   = (state == ST_BLOCK);
    end

    bfg_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (reg_rd),
        .wr      (reg_wr),
        .word    (reg_word),
        .wdata   (reg_wdata),
        .cfg     (cfg),
        .blk_set (blk_set),
        .rdata   (reg_rdata),
        .viol    (viol)
    );

endmodule

// File: rtl/bfg_checker.sv
module bfg_checker #(
    parameter int ADDR_W    = 32,
    parameter int REGION_AW = 21,
    parameter int STRAP_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_req,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_ack,
    input logic               mem_cs,
    input logic               mem_we,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               wen_ok,
    input logic [STRAP_W-1:0] fitted,
    input logic               in_sync,
    input logic               viol,
    input logic               reg_wr,
    input logic [1:0]         reg_word,
    input logic               clr_bit
);

    localparam int TAG_LSB = REGION_AW + 2;

    p_ack_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    p_ack_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_req));

    p_no_ack_in_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_sync |-> !bus_ack);

    p_we_needs_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_cs);

    p_block_only_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !mem_cs) |-> (!wen_ok && $past(bus_we)));

    p_read_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !$past(bus_we)) |-> (mem_cs && !mem_we));

    p_low_bits_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs |-> (mem_addr[REGION_AW-1:0] == $past(bus_addr[REGION_AW-1:0])));

    p_tag_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs |-> (mem_addr[ADDR_W-1:TAG_LSB] == $past(bus_addr[ADDR_W-1:TAG_LSB])));

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_sync && !$past(in_sync)) |-> $stable(fitted));

    p_viol_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(viol && !(reg_wr && reg_word == 2'd2 && clr_bit)) |-> viol);

    p_viol_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol) |-> $past(bus_ack && !mem_cs));

endmodule

bind boot_flash_guard bfg_checker #(
    .ADDR_W    (ADDR_W),
    .REGION_AW (REGION_AW),
    .STRAP_W   (bfg_pkg::STRAP_W)
) u_bfg_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_ack  (bus_ack),
    .mem_cs   (mem_cs),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .wen_ok   (cfg.wen),
    .fitted   (fitted),
    .in_sync  (in_sync),
    .viol     (viol),
    .reg_wr   (reg_wr),
    .reg_word (reg_word),
    .clr_bit  (reg_wdata[bfg_pkg::VIOL_BIT])
);

// File: tb/test_boot_flash_guard.sv
`timescale 1ns/1ps
module test_boot_flash_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  strap_n = 4'hF;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic        bus_ack, mem_cs, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [1:0]  reg_word = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    logic [3:0] cur_fit;

    typedef struct {
        logic        cs;
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        string       req;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    boot_flash_guard i_boot_flash_guard (
        .clk(clk), .rst_n(rst_n), .strap_n(strap_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .mem_cs(mem_cs), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_word(reg_word),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_addr(input logic [31:0] a);
        logic [31:0] r = a;
        if (a[31:23] == 9'h1FF) r[22:21] = a[22:21] ^ cur_fit[3:2];
        return r;
    endfunction

    // Monitor: pops one expected item per acknowledge
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && bus_ack === 1'b1) begin
            if (q.size() == 0) begin
                chk(1'b0, "R10", "ack with nothing pending", 32'(bus_ack), 32'h0);
            end else begin
                e = q.pop_front();
                chk(mem_cs === e.cs, e.req, "mem_cs", 32'(mem_cs), 32'(e.cs));
                chk(mem_we === e.we, e.req, "mem_we", 32'(mem_we), 32'(e.we));
                if (e.cs) begin
                    chk(mem_addr === e.addr, e.req, "mem_addr", mem_addr, e.addr);
                    if (e.we) chk(mem_wdata === e.wdata, e.req, "mem_wdata", mem_wdata, e.wdata);
                end
            end
        end
    end

    // Driver: pushes the expected result, then issues the access
    task automatic access(input logic [31:0] a, input logic we, input logic [31:0] d,
                          input string req);
        exp_t e;
        logic blocked = we && (a[31:23] == 9'h1FF) && !cur_fit[1];
        e.cs = !blocked; e.we = we && !blocked; e.addr = model_addr(a);
        e.wdata = d; e.req = req;
        q.push_back(e);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_reg(input logic [1:0] w, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_rd = 1'b1; reg_word = w;
        @(negedge clk);
        reg_rd = 1'b0;
        chk(reg_rdata === exp, req, $sformatf("reg word %0d", w), reg_rdata, exp);
    endtask

    task automatic wr_reg(input logic [1:0] w, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_word = w; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic start(input logic [3:0] s);
        strap_n = s;
        cur_fit = ~s;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(bus_ack === 1'b0 && mem_cs === 1'b0 && mem_we === 1'b0, "R10",
            "outputs in reset", {29'b0, bus_ack, mem_cs, mem_we}, 32'h0);
        chk(reg_rdata === 32'h0, "R10", "reg_rdata in reset", reg_rdata, 32'h0);
        rst_n = 1'b1;
        // Request while the straps are still settling: must be ignored
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 32'h0000_1000;
        @(negedge clk);
        bus_req = 1'b0;
        chk(bus_ack === 1'b0, "R10", "no ack during SYNC", 32'(bus_ack), 32'h0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        // Nothing fitted: code 0, writes locked, passwords hidden
        start(4'b1111);
        rd_reg(2'd2, 32'h0000_0000, "R8");
        rd_reg(2'd0, 32'h6C6F_636B, "R7");
        rd_reg(2'd1, 32'h6C6F_636B, "R7");
        rd_reg(2'd3, 32'h0000_0000, "R8");
        access(32'hFFE0_0010, 1'b0, 32'h0, "R5");
        access(32'hFF80_0004, 1'b1, 32'hDEAD_BEEF, "R3");
        rd_reg(2'd2, 32'h0000_0010, "R6");
        access(32'h1000_0000, 1'b1, 32'h1234_5678, "R1");
        wr_reg(2'd2, 32'hFFFF_FFEF);
        rd_reg(2'd2, 32'h0000_0010, "R6");
        wr_reg(2'd2, 32'h0000_0010);
        rd_reg(2'd2, 32'h0000_0000, "R6");

        // Pins change after the latch: no effect
        strap_n = 4'b0000;
        repeat (6) @(negedge clk);
        rd_reg(2'd2, 32'h0000_0000, "R9");
        rd_reg(2'd0, 32'h6C6F_636B, "R9");
        access(32'hFFC0_0020, 1'b1, 32'h5555_AAAA, "R9");
        access(32'hFFE0_0040, 1'b0, 32'h0, "R9");

        // All fitted: code 3, writes open, passwords visible
        start(4'b0000);
        rd_reg(2'd2, 32'h0000_000F, "R8");
        rd_reg(2'd0, 32'h4461_7461, "R7");
        rd_reg(2'd1, 32'h5361_6665, "R7");
        access(32'hFFFF_FFF0, 1'b0, 32'h0, "R2");
        access(32'hFF80_0000, 1'b1, 32'hA5A5_0001, "R4");
        access(32'hFF7F_FFFC, 1'b1, 32'h0BAD_F00D, "R1");
        access(32'hFF7F_FFFC, 1'b0, 32'h0, "R1");
        rd_reg(2'd2, 32'h0000_000F, "R6");

        // Mixed: code 1, writes open, passwords hidden
        start(4'b1001);
        rd_reg(2'd2, 32'h0000_0006, "R8");
        rd_reg(2'd1, 32'h6C6F_636B, "R7");
        access(32'hFFA0_0000, 1'b0, 32'h0, "R2");
        access(32'hFFC1_2344, 1'b1, 32'h0F0F_F0F0, "R4");
        access(32'h7FE0_0000, 1'b0, 32'h0, "R1");

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R10", "pending accesses never acknowledged", 32'(q.size()), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired act=%h exp=%h", 32'h1, 32'h0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule